// File: doc/BRIEF.md
# Capability Access Guard

This block decides, in the same cycle an access is presented, whether a memory reference made through a capability register may proceed. A capability is a 128-bit word carrying an explicit lowest and highest reachable byte address in a 48-bit virtual space, plus a small set of permission bits. A separate validity tag travels with the register. The guard combines the operation class, the effective address and access length, the capability, its tag and a global enforcement mode bit. From these it produces an allow signal and a fault code. When an access is refused, a trap pulse and its cause are registered for exactly one cycle so the pipeline can redirect.

The guard also tells the tag store what to do with the 16-byte line an allowed store touches. Only a capability store may set the line's tag, and it copies the tag of the value being stored. Every other store clears the tag. Because of this, two ordinary stores that write the halves of a capability image never leave a valid tag behind.

Top module: `cap_guard`

## Requirements
- R1: While reset is low and after it is released with no access presented, `trap_pulse` and `trap_cause` are 0.
- R2: Capability layout: bits 47:0 hold the lower bound, bits 95:48 the upper bound (inclusive), bits 100:96 the permissions (bit 96 read, 97 write, 98 execute, 99 load-capability, 100 store-capability), and bits 127:101 are reserved. Operation codes on `acc_op`: 0 plain load, 1 plain store, 2 data load through capability, 3 data store through capability, 4 capability load, 5 capability store, 6 call/jump through pointer, 7 PC-relative access. Ops 2, 3, 4, 5 and 6 each require read, write, load-capability, store-capability and execute respectively.
- R3: For ops 2 to 6, a clear `cap_tag` or any nonzero reserved bit is refused with cause 1 (untagged).
- R4: Plain loads and stores (ops 0, 1) are refused with cause 2 (instruction class) when `cap_mode_en` is 1. They are allowed unchecked when it is 0.
- R5: PC-relative accesses (op 7) are always allowed, whatever the mode, tag or capability.
- R6: For ops 2 to 6, a missing required permission bit gives cause 3. An execute-only capability therefore allows op 6 and refuses ops 2 and 4.
- R7: For ops 2 to 6, the access is in bounds only if lower <= addr and addr + `acc_len_m1` <= upper, computed without wrap-around. Otherwise the cause is 4.
- R8: When several faults apply, the reported cause follows the priority untagged (1), instruction class (2), permission (3), bounds (4). Cause 0 means no fault.
- R9: One cycle after a valid refused access, `trap_pulse` is 1 and `trap_cause` holds its code. After any other cycle, both are 0.
- R10: On an allowed store (ops 1, 3, 5), `line_tag_we` is 1. `line_tag_val` equals `src_tag` for op 5 and is 0 for ops 1 and 3.
- R11: Ops 2 to 6 are checked identically whether `cap_mode_en` is 0 or 1.
- R12: With `acc_valid` low, `acc_allow` and `line_tag_we` are 0 and no trap follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_op | input | 3 | Operation code (R2) |
| acc_addr | input | 48 | Effective byte address |
| acc_len_m1 | input | 4 | Access length in bytes minus one |
| cap_word | input | 128 | Authorising capability |
| cap_tag | input | 1 | Validity tag of the capability register |
| cap_mode_en | input | 1 | Global capability enforcement mode |
| src_tag | input | 1 | Tag of the value written by a capability store |
| acc_allow | output | 1 | Access may proceed (combinational) |
| line_tag_we | output | 1 | Update the tag of the touched 16-byte line |
| line_tag_val | output | 1 | New tag value for that line |
| trap_pulse | output | 1 | Registered one-cycle trap indication |
| trap_cause | output | 3 | Registered fault code |

## Verification
The assertions take for granted that all inputs hold steady and known between clock edges, and that `acc_op` always carries one of the eight defined codes. They also assume the bounds in a capability are whatever software left there, so no ordering between lower and upper bound is presumed. The stimulus changes inputs only at the falling edge and draws only defined op codes. Besides random traffic, it deliberately builds capabilities with reserved bits set, inverted bounds, and ranges that end at the top of the address space, so that the wrap-free bounds rule is exercised against the assumptions rather than around them.

// File: rtl/cap_guard_pkg.sv
// Shared types for the capability access guard.
// Assumes: op and fault codes fit in three bits; permission indices are
// positions inside the permission field of a capability word.
package cap_guard_pkg;

    typedef enum logic [2:0] {
        OP_LD_PLAIN = 3'd0,
        OP_ST_PLAIN = 3'd1,
        OP_LD_DATA  = 3'd2,
        OP_ST_DATA  = 3'd3,
        OP_LD_CAP   = 3'd4,
        OP_ST_CAP   = 3'd5,
        OP_JUMP     = 3'd6,
        OP_PCREL    = 3'd7
    } acc_op_e;

    typedef enum logic [2:0] {
        FLT_NONE   = 3'd0,
        FLT_UNTAG  = 3'd1,
        FLT_CLASS  = 3'd2,
        FLT_PERM   = 3'd3,
        FLT_BOUNDS = 3'd4
    } fault_e;

    localparam int PERM_N  = 5;
    localparam int PERM_RD = 0;
    localparam int PERM_WR = 1;
    localparam int PERM_EX = 2;
    localparam int PERM_LC = 3;
    localparam int PERM_SC = 4;

    // True for operations authorised by the capability register.
    function automatic logic op_uses_cap(input acc_op_e op);
        return (op == OP_LD_DATA) || (op == OP_ST_DATA) || (op == OP_LD_CAP) ||
               (op == OP_ST_CAP)  || (op == OP_JUMP);
    endfunction

    // True for ordinary moves that bypass the capability.
    function automatic logic op_is_plain(input acc_op_e op);
        return (op == OP_LD_PLAIN) || (op == OP_ST_PLAIN);
    endfunction

endpackage

// File: rtl/cap_range_chk.sv
// Bounds check: the access [addr, addr+len_m1] must lie inside [lo, hi].
// Assumes: hi is inclusive; the end address is formed one bit wider so a
// range running past the top of the address space is never accepted.
module cap_range_chk #(
    parameter int VA_W  = 48,
    parameter int LEN_W = 4
) (
    input  logic [VA_W-1:0]  addr,
    input  logic [LEN_W-1:0] len_m1,
    input  logic [VA_W-1:0]  lo,
    input  logic [VA_W-1:0]  hi,
    output logic             in_range
);
    localparam int EXT_W = VA_W + 1;

    logic [EXT_W-1:0] last_byte;
    logic             above_lo;
    logic             below_hi;

    // Compute the last byte address without wrap and compare both ends.
    always_comb begin
        last_byte = {1'b0, addr} + EXT_W'(len_m1);
        above_lo  = (addr >= lo);
        below_hi  = (last_byte <= {1'b0, hi});
        in_range  = above_lo && below_hi;
    end
endmodule

// File: rtl/cap_perm_chk.sv
// Permission check: each capability-authorised op needs one permission bit.
// Assumes: ops that do not use the capability need no bit and always pass.
module cap_perm_chk
    import cap_guard_pkg::*;
#(
    parameter int NPERM = PERM_N
) (
    input  acc_op_e          op,
    input  logic [NPERM-1:0] perms,
    output logic [NPERM-1:0] need,
    output logic             perm_ok
);
    // Map the operation to the single permission bit it requires.
    always_comb begin
        need = '0;
        case (op)
            OP_LD_DATA: need[PERM_RD] = 1'b1;
            OP_ST_DATA: need[PERM_WR] = 1'b1;
            OP_LD_CAP:  need[PERM_LC] = 1'b1;
            OP_ST_CAP:  need[PERM_SC] = 1'b1;
            OP_JUMP:    need[PERM_EX] = 1'b1;
            default:    need = '0;
        endcase
    end

    // Every required bit must be granted.
    always_comb perm_ok = ((need & ~perms) == '0);
endmodule

// File: rtl/cap_fault_sel.sv
// Fault prioritisation and trap register.
// Assumes: the per-check results arrive in the same cycle as acc_valid; the
// trap and cause are valid for exactly the cycle after the refused access.
module cap_fault_sel
    import cap_guard_pkg::*;
#(
    parameter int CAUSE_W = 3,
    parameter int NPERM   = PERM_N
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               valid,
    input  logic               uses_cap,
    input  logic               is_plain,
    input  logic               mode_en,
    input  logic               tag_ok,
    input  logic               perm_ok,
    input  logic [NPERM-1:0]   need,
    input  logic               bounds_ok,
    output logic               allow,
    output logic               trap_q,
    output logic [CAUSE_W-1:0] cause_q
);
    fault_e fault;

    // Pick the highest-priority fault for the current access.
    always_comb begin
        fault = FLT_NONE;
        if (is_plain && mode_en) begin
            fault = FLT_CLASS;
        end else if (uses_cap) begin
            if (!tag_ok)         fault = FLT_UNTAG;
            else if (!perm_ok)   fault = FLT_PERM;
            else if (!bounds_ok) fault = FLT_BOUNDS;
        end
    end

    // Grant only a presented access with no fault.
    always_comb allow = valid && (fault == FLT_NONE);

    // Register the trap pulse and its cause for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trap_q  <= 1'b0;
            cause_q <= '0;
        end else begin
            trap_q  <= valid && (fault != FLT_NONE);
            cause_q <= valid ? CAUSE_W'(fault) : '0;
        end
    end

    // R9: a trap always carries a nonzero cause, and no cause without a trap.
    assert_cause_pairs_R9: assert property (@(posedge clk) disable iff (!rst_n)
        trap_q == (cause_q != '0));

    // R9: a refused access is followed by a trap pulse.
    assert_trap_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !allow) |=> trap_q);

    // R9: an idle or granted cycle leaves no trap behind.
    assert_no_spurious_trap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid || allow) |=> !trap_q);

    // R2: at most one permission bit is required by any operation.
    assert_single_need_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(need));
endmodule

// File: rtl/cap_guard.sv
// Capability access guard, top level.
// Decodes the capability word, runs the tag, class, permission and bounds
// checks, and drives the line-tag update for allowed stores.
// Assumes: inputs are stable between clock edges; reserved capability bits
// must be zero for the capability to count as well-formed.
module cap_guard
    import cap_guard_pkg::*;
#(
    parameter int VA_W    = 48,
    parameter int CAP_W   = 128,
    parameter int LEN_W   = 4,
    parameter int CAUSE_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc_valid,
    input  logic [2:0]         acc_op,
    input  logic [VA_W-1:0]    acc_addr,
    input  logic [LEN_W-1:0]   acc_len_m1,
    input  logic [CAP_W-1:0]   cap_word,
    input  logic               cap_tag,
    input  logic               cap_mode_en,
    input  logic               src_tag,
    output logic               acc_allow,
    output logic               line_tag_we,
    output logic               line_tag_val,
    output logic               trap_pulse,
    output logic [CAUSE_W-1:0] trap_cause
);
    localparam int LO_LSB   = 0;
    localparam int HI_LSB   = VA_W;
    localparam int PERM_LSB = 2 * VA_W;
    localparam int RSV_LSB  = PERM_LSB + PERM_N;
    localparam int RSV_W    = CAP_W - RSV_LSB;

    acc_op_e            op;
    logic [VA_W-1:0]    cap_lo;
    logic [VA_W-1:0]    cap_hi;
    logic [PERM_N-1:0]  cap_perms;
    logic [RSV_W-1:0]   cap_rsv;
    logic               tag_ok;
    logic               perm_ok;
    logic               bounds_ok;
    logic               uses_cap;
    logic               is_plain;
    logic               is_store;
    logic [PERM_N-1:0]  need;

    // Split the capability into its fields and classify the operation.
    always_comb begin
        op        = acc_op_e'(acc_op);
        cap_lo    = cap_word[LO_LSB   +: VA_W];
        cap_hi    = cap_word[HI_LSB   +: VA_W];
        cap_perms = cap_word[PERM_LSB +: PERM_N];
        cap_rsv   = cap_word[RSV_LSB  +: RSV_W];
        tag_ok    = cap_tag && (cap_rsv == '0);
        uses_cap  = op_uses_cap(op);
        is_plain  = op_is_plain(op);
        is_store  = (op == OP_ST_PLAIN) || (op == OP_ST_DATA) || (op == OP_ST_CAP);
    end

    cap_range_chk #(.VA_W(VA_W), .LEN_W(LEN_W)) u_range (
        .addr     (acc_addr),
        .len_m1   (acc_len_m1),
        .lo       (cap_lo),
        .hi       (cap_hi),
        .in_range (bounds_ok)
    );

    cap_perm_chk #(.NPERM(PERM_N)) u_perm (
        .op      (op),
        .perms   (cap_perms),
        .need    (need),
        .perm_ok (perm_ok)
    );

    cap_fault_sel #(.CAUSE_W(CAUSE_W), .NPERM(PERM_N)) u_fault (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid     (acc_valid),
        .uses_cap  (uses_cap),
        .is_plain  (is_plain),
        .mode_en   (cap_mode_en),
        .tag_ok    (tag_ok),
        .perm_ok   (perm_ok),
        .need      (need),
        .bounds_ok (bounds_ok),
        .allow     (acc_allow),
        .trap_q    (trap_pulse),
        .cause_q   (trap_cause)
    );

    // Allowed stores rewrite the line tag; only a capability store may set it.
    always_comb begin
        line_tag_we  = acc_allow && is_store;
        line_tag_val = line_tag_we && (op == OP_ST_CAP) && src_tag;
    end

    // R5: PC-relative accesses are never refused.
    assert_pcrel_open_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && op == OP_PCREL) |-> acc_allow);

    // R4: with enforcement off, ordinary moves go through.
    assert_plain_open_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && is_plain && !cap_mode_en) |-> acc_allow);

    // R3: an untagged capability never authorises an access.
    assert_untagged_block_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && uses_cap && !cap_tag) |-> !acc_allow);

    // R10: a set line tag only ever comes from an allowed capability store.
    assert_tag_set_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
        line_tag_val |-> (line_tag_we && op == OP_ST_CAP && src_tag));

    // R12: nothing is granted or written while idle.
    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |-> (!acc_allow && !line_tag_we));
endmodule

// File: tb/cap_guard_tb_top.sv
`timescale 1ns/1ps
module cap_guard_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         acc_valid = 1'b0;
    logic [2:0]   acc_op = 3'd0;
    logic [47:0]  acc_addr = '0;
    logic [3:0]   acc_len_m1 = '0;
    logic [127:0] cap_word = '0;
    logic         cap_tag = 1'b0;
    logic         cap_mode_en = 1'b0;
    logic         src_tag = 1'b0;
    logic         acc_allow, line_tag_we, line_tag_val, trap_pulse;
    logic [2:0]   trap_cause;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    cap_guard dut_i (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_op(acc_op),
        .acc_addr(acc_addr), .acc_len_m1(acc_len_m1), .cap_word(cap_word),
        .cap_tag(cap_tag), .cap_mode_en(cap_mode_en), .src_tag(src_tag),
        .acc_allow(acc_allow), .line_tag_we(line_tag_we),
        .line_tag_val(line_tag_val), .trap_pulse(trap_pulse),
        .trap_cause(trap_cause)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    // Behavioural reference for one access, taken from the requirement list.
    function automatic void predict(
        input logic [2:0] op, input logic [47:0] addr, input logic [3:0] len,
        input logic [127:0] cap, input logic tag, input logic en,
        input logic stag, input logic v,
        output logic a, output logic [2:0] c, output logic we, output logic val);
        logic [63:0] lo, hi, first, last;
        int bitpos;
        lo    = {16'h0, cap[47:0]};
        hi    = {16'h0, cap[95:48]};
        first = {16'h0, addr};
        last  = first + {60'h0, len};
        c     = 3'd0;
        if (op == 3'd0 || op == 3'd1) begin
            if (en) c = 3'd2;
        end else if (op != 3'd7) begin
            case (op)
                3'd2: bitpos = 96;
                3'd3: bitpos = 97;
                3'd4: bitpos = 99;
                3'd5: bitpos = 100;
                default: bitpos = 98;
            endcase
            if (!tag || cap[127:101] != 27'h0) c = 3'd1;
            else if (!cap[bitpos])             c = 3'd3;
            else if (first < lo || last > hi)  c = 3'd4;
        end
        a   = v && (c == 3'd0);
        we  = a && (op == 3'd1 || op == 3'd3 || op == 3'd5);
        val = we && (op == 3'd5) && stag;
        if (!v) c = 3'd0;
    endfunction

    function automatic logic [127:0] mkcap(input logic [47:0] lo, input logic [47:0] hi,
                                           input logic [4:0] perms);
        return {27'h0, perms, hi, lo};
    endfunction

    // Present one access, compare the same-cycle and next-cycle outputs.
    task automatic access(input string req, input logic v, input logic [2:0] op,
                          input logic [47:0] addr, input logic [3:0] len,
                          input logic [127:0] cap, input logic tag,
                          input logic en, input logic stag);
        logic ea, ewe, evl;
        logic [2:0] ec;
        @(negedge clk);
        acc_valid = v; acc_op = op; acc_addr = addr; acc_len_m1 = len;
        cap_word = cap; cap_tag = tag; cap_mode_en = en; src_tag = stag;
        predict(op, addr, len, cap, tag, en, stag, v, ea, ec, ewe, evl);
        #1;
        chk(req, "allow", {63'h0, acc_allow}, {63'h0, ea});
        chk(req, "tag_we", {63'h0, line_tag_we}, {63'h0, ewe});
        chk(req, "tag_val", {63'h0, line_tag_val}, {63'h0, evl});
        @(posedge clk);
        #1;
        chk(req, "trap", {63'h0, trap_pulse}, {63'h0, (v && ec != 3'd0)});
        chk(req, "cause", {61'h0, trap_cause}, {61'h0, ec});
    endtask

    task automatic summary;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
        end
    end

    initial begin : stimulus
        logic [127:0] full, xonly, c2;
        logic [63:0]  r;
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "trap in reset", {63'h0, trap_pulse}, 64'h0);
        chk("R1", "cause in reset", {61'h0, trap_cause}, 64'h0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1", "trap after reset", {63'h0, trap_pulse}, 64'h0);
        chk("R1", "cause after reset", {61'h0, trap_cause}, 64'h0);

        full  = mkcap(48'h1000, 48'h1FFF, 5'b11111);
        xonly = mkcap(48'h1000, 48'h1FFF, 5'b00100);

        // R7: exact edges of the range and one byte past each
        access("R7", 1, 3'd2, 48'h1000, 4'd7, full, 1, 0, 0);
        access("R7", 1, 3'd2, 48'h1FF8, 4'd7, full, 1, 0, 0);
        access("R7", 1, 3'd2, 48'h1FF9, 4'd7, full, 1, 0, 0);
        access("R7", 1, 3'd3, 48'h0FFF, 4'd0, full, 1, 1, 0);
        // R7: range ending at the top of the space must not wrap
        access("R7", 1, 3'd2, 48'hFFFF_FFFF_FFF8, 4'd15,
               mkcap(48'hFFFF_FFFF_FF00, 48'hFFFF_FFFF_FFFF, 5'b11111), 1, 0, 0);
        // R3: untagged and reserved-bit capabilities
        access("R3", 1, 3'd2, 48'h1000, 4'd0, full, 0, 0, 0);
        c2 = full; c2[120] = 1'b1;
        access("R3", 1, 3'd6, 48'h1000, 4'd0, c2, 1, 0, 0);
        // R6: execute-only pointer
        access("R6", 1, 3'd6, 48'h1100, 4'd3, xonly, 1, 1, 0);
        access("R6", 1, 3'd2, 48'h1100, 4'd3, xonly, 1, 1, 0);
        access("R6", 1, 3'd4, 48'h1100, 4'd15, xonly, 1, 0, 0);
        // R4: class gating
        access("R4", 1, 3'd0, 48'h5, 4'd0, full, 0, 1, 0);
        access("R4", 1, 3'd1, 48'h5, 4'd0, full, 0, 1, 0);
        access("R4", 1, 3'd0, 48'h5, 4'd0, full, 0, 0, 0);
        // R5: PC-relative exempt
        access("R5", 1, 3'd7, 48'hDEAD, 4'd15, 128'h0, 0, 1, 0);
        // R8: priority
        access("R8", 1, 3'd3, 48'h9999, 4'd0, xonly, 0, 0, 0);
        access("R8", 1, 3'd3, 48'h9999, 4'd0, xonly, 1, 0, 0);
        // R10: tag updates on stores
        access("R10", 1, 3'd5, 48'h1010, 4'd15, full, 1, 1, 1);
        access("R10", 1, 3'd1, 48'h1010, 4'd7, full, 0, 0, 1);
        access("R10", 1, 3'd1, 48'h1018, 4'd7, full, 0, 0, 1);
        access("R10", 1, 3'd3, 48'h1010, 4'd7, full, 1, 1, 1);
        access("R10", 1, 3'd5, 48'h3010, 4'd15, full, 1, 1, 1);
        // R11: same result under both modes
        access("R11", 1, 3'd4, 48'h1FF0, 4'd15, full, 1, 0, 0);
        access("R11", 1, 3'd4, 48'h1FF0, 4'd15, full, 1, 1, 0);
        // R12: idle cycle with a faulty-looking access
        access("R12", 0, 3'd2, 48'h0, 4'd0, full, 0, 1, 0);
        // inverted bounds refuse every capability access
        access("R7", 1, 3'd2, 48'h1800, 4'd0, mkcap(48'h2000, 48'h1000, 5'b11111), 1, 0, 0);

        // R2: mixed traffic over all op codes and permission patterns
        for (int i = 0; i < 600; i++) begin
            logic [47:0] lo, addr;
            logic [4:0]  pr;
            r    = {$urandom(), $urandom()};
            lo   = {r[47:12], 12'h0};
            pr   = 5'($urandom_range(0, 31));
            c2   = mkcap(lo, lo + 48'h0FF, pr);
            if ($urandom_range(0, 15) == 0) c2[101 + $urandom_range(0, 26)] = 1'b1;
            addr = lo - 48'h8 + 48'($urandom_range(0, 280));
            access("R2", ($urandom_range(0, 7) != 0), 3'($urandom_range(0, 7)), addr,
                   4'($urandom_range(0, 15)), c2, ($urandom_range(0, 7) != 0),
                   1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        end

        done = 1'b1;
        summary();
    end
endmodule